// File: doc/BRIEF.md
# Adaptive Insertion Replacement Controller

This block holds the tags, valid bits and a full recency order for every set of a small set-associative cache, and it decides where a newly filled line enters that order. A lookup presents a set index and a tag with a strobe. One cycle later the block answers with a hit flag, the way that hit or was filled, and the way that was least recently used when the lookup arrived. On a miss the tag is written into that least-recently-used way at once, so the victim choice never depends on the insertion policy.

Two insertion placements compete. Conventional insertion puts the filled way at the most-recent end of the order. Bimodal insertion leaves it at the least-recent end, unless a free-running pseudo-random draw comes up, in which case it goes to the most-recent end. A few sets are fixed leaders for each placement, found by comparing the two halves of the set index. A shared saturating selector counter is raised by misses in conventional leaders and lowered by misses in bimodal leaders. All other sets follow the placement that the counter currently favours. The mode register has two states: FOLLOW_MRU_INS (follower fills go to the most-recent end) and FOLLOW_BIMODAL (follower fills use bimodal placement). The transition T_ENTER_BIMODAL is taken when the counter's next value reaches the midpoint or above, and T_ENTER_MRU_INS is taken when it falls below the midpoint. The selector counter and the leader decode are the only adaptation state, and no bit is added to any tag entry.

Top module: `adapt_ins_ctrl`

## Requirements
- R1: After reset every way of every set is invalid, way w sits at recency position w (position 0 most recent, so way WAYS-1 is least recent), the selector counter holds 512, `follow_bimodal` is 1 and `rsp_valid` is 0.
- R2: A lookup strobed at a clock edge gives `rsp_valid`=1 after that edge, with `rsp_hit`=1 and `rsp_way` equal to the matching way when a valid way of the set holds the tag; otherwise `rsp_hit`=0. With no strobe, `rsp_valid` is 0.
- R3: `rsp_victim` is the way at the least-recent position of the set when the lookup arrives, under every policy; on a miss the tag is written into that way, the way becomes valid and `rsp_way` equals `rsp_victim`.
- R4: On a hit the hit way moves to the most-recent position and every way that was more recent than it moves one step toward the least-recent end; `rsp_fill_mru` is 0.
- R5: A set whose low IDX_W/2 index bits equal its high IDX_W/2 index bits is a conventional leader: every miss puts the filled way at the most-recent position, shifting all others one step older, and `rsp_fill_mru` is 1.
- R6: A set whose low IDX_W/2 index bits equal the bitwise complement of its high bits is a bimodal leader: a miss goes to the most-recent position (`rsp_fill_mru`=1) only when the 5-bit draw register equals 5'b11111, otherwise the filled way stays least recent and the order is unchanged (`rsp_fill_mru`=0). The draw register resets to 5'b00001 and on every clock becomes {d[3:0], d[4]^d[2]}.
- R7: Every other set uses conventional placement while `follow_bimodal` is 0 and bimodal placement (as in R6) while it is 1, taken from the value before the lookup edge.
- R8: The selector counter is 10 bits, rises by one on a miss in a conventional leader (held at 1023), falls by one on a miss in a bimodal leader (held at 0) and is unchanged by hits and follower lookups; `follow_bimodal` is 1 exactly when the counter is 512 or more, updated at the same edge.
- R9: Back-to-back lookups to the same set see each other's update: a lookup in the cycle after a miss on the same tag reports a hit on the filled way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup strobe |
| lk_set | input | IDX_W | Set index of the lookup |
| lk_tag | input | TAG_W | Tag of the lookup |
| rsp_valid | output | 1 | Response present for the previous cycle's lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | $clog2(WAYS) | Hit way, or filled way on a miss |
| rsp_victim | output | $clog2(WAYS) | Least-recent way at lookup time |
| rsp_fill_mru | output | 1 | Miss fill placed at the most-recent position |
| follow_bimodal | output | 1 | Follower sets currently use bimodal placement |

## Verification
The assertions take for granted that no set ever holds the same valid tag in two ways, which the block itself keeps true because a tag is installed only after it missed. They also assume `lk_valid` is never unknown once reset is released. The stimulus respects this by driving only defined values at the falling edge. It uses a small tag range in the mixed phase to force repeated hits, and fresh increasing tags when the selector counter must be pushed to each saturation limit and back across the midpoint.

// File: rtl/ains_pkg.sv
package ains_pkg;

    typedef enum logic [1:0] {
        SET_FOLLOWER     = 2'd0,
        SET_LEAD_MRU     = 2'd1,
        SET_LEAD_BIMODAL = 2'd2
    } set_class_e;

    typedef enum logic {
        FOLLOW_MRU_INS = 1'b0,
        FOLLOW_BIMODAL = 1'b1
    } follow_mode_e;

endpackage

// File: rtl/ains_set_classify.sv
module ains_set_classify
    import ains_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] set_idx,
    output set_class_e       set_class
);
    localparam int HALF = IDX_W / 2;

    logic [HALF-1:0] lo_bits;
    logic [HALF-1:0] hi_bits;

    assign lo_bits = set_idx[HALF-1:0];
    assign hi_bits = set_idx[IDX_W-1 -: HALF];

    always_comb begin
        if (lo_bits == hi_bits) begin
            set_class = SET_LEAD_MRU;
        end else if (lo_bits == ~hi_bits) begin
            set_class = SET_LEAD_BIMODAL;
        end else begin
            set_class = SET_FOLLOWER;
        end
    end
endmodule

// File: rtl/ains_draw_lfsr.sv
module ains_draw_lfsr #(
    parameter int W   = 5,
    parameter int TAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic draw_hit
);
    logic [W-1:0] shift_q;
    logic         feedback;

    assign feedback = shift_q[W-1] ^ shift_q[TAP-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= W'(1);
        end else begin
            shift_q <= {shift_q[W-2:0], feedback};
        end
    end

    assign draw_hit = (shift_q == '1);

    AST_DRAW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        shift_q != '0); // R6
endmodule

// File: rtl/ains_sel_fsm.sv
module ains_sel_fsm
    import ains_pkg::*;
#(
    parameter int CTR_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump_up,
    input  logic bump_down,
    output logic follow_bimodal
);
    localparam logic [CTR_W-1:0] CTR_MAX = '1;
    localparam logic [CTR_W-1:0] CTR_MID = {1'b1, {(CTR_W-1){1'b0}}};

    follow_mode_e     mode_q, mode_d;
    logic [CTR_W-1:0] ctr_q, ctr_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= FOLLOW_BIMODAL;
            ctr_q  <= CTR_MID;
        end else begin
            mode_q <= mode_d;
            ctr_q  <= ctr_d;
        end
    end

    // next counter and transitions
    always_comb begin
        ctr_d = ctr_q;
        if (bump_up && ctr_q != CTR_MAX) begin
            ctr_d = ctr_q + 1'b1;
        end else if (bump_down && ctr_q != '0) begin
            ctr_d = ctr_q - 1'b1;
        end
        mode_d = mode_q;
        unique case (mode_q)
            FOLLOW_MRU_INS: if (ctr_d >= CTR_MID) mode_d = FOLLOW_BIMODAL; // T_ENTER_BIMODAL
            FOLLOW_BIMODAL: if (ctr_d <  CTR_MID) mode_d = FOLLOW_MRU_INS; // T_ENTER_MRU_INS
            default:        mode_d = FOLLOW_BIMODAL;
        endcase
    end

    // outputs
    always_comb begin
        unique case (mode_q)
            FOLLOW_MRU_INS: follow_bimodal = 1'b0;
            FOLLOW_BIMODAL: follow_bimodal = 1'b1;
            default:        follow_bimodal = 1'b1;
        endcase
    end

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q != $past(ctr_q)) |-> ((ctr_q == $past(ctr_q) + 1'b1) || (ctr_q == $past(ctr_q) - 1'b1))); // R8
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bump_up || bump_down) |=> $stable(ctr_q)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_up && ctr_q == CTR_MAX) |=> (ctr_q == CTR_MAX)); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_down && ctr_q == '0) |=> (ctr_q == '0)); // R8
    AST_MODE_TRACKS_CTR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == FOLLOW_BIMODAL) == (ctr_q >= CTR_MID)); // R8
endmodule

// File: rtl/ains_recency_store.sv
module ains_recency_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int TAG_W = 12,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [IDX_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             fill_mru,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] victim_way
);
    localparam logic [WAY_W-1:0] LRU_AGE = WAY_W'(WAYS - 1);

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic             vld_q [SETS][WAYS];
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    logic [WAYS-1:0]  hit_vec;
    logic [WAYS-1:0]  lru_vec;
    logic [WAY_W-1:0] tgt_way;
    logic [WAY_W-1:0] ref_age;
    logic             promote;

    always_comb begin
        hit_way    = '0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
            lru_vec[w] = (age_q[lk_set][w] == LRU_AGE);
            if (hit_vec[w]) hit_way    = WAY_W'(w);
            if (lru_vec[w]) victim_way = WAY_W'(w);
        end
        hit     = |hit_vec;
        tgt_way = hit ? hit_way : victim_way;
        ref_age = hit ? age_q[lk_set][hit_way] : LRU_AGE;
        promote = hit || fill_mru;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    vld_q[s][w] <= 1'b0;
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (lk_valid) begin
            if (!hit) begin
                tag_q[lk_set][victim_way] <= lk_tag;
                vld_q[lk_set][victim_way] <= 1'b1;
            end
            if (promote) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == tgt_way) begin
                        age_q[lk_set][w] <= '0;
                    end else if (age_q[lk_set][w] < ref_age) begin
                        age_q[lk_set][w] <= age_q[lk_set][w] + 1'b1;
                    end
                end
            end
        end
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(hit_vec)); // R2
    AST_ONE_LRU: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ($countones(lru_vec) == 1)); // R3
endmodule

// File: rtl/adapt_ins_ctrl.sv
module adapt_ins_ctrl
    import ains_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 12,
    parameter int CTR_W  = 10,
    parameter int DRAW_W = 5,
    parameter int DRAW_TAP = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [IDX_W-1:0]        lk_set,
    input  logic [TAG_W-1:0]        lk_tag,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [$clog2(WAYS)-1:0] rsp_way,
    output logic [$clog2(WAYS)-1:0] rsp_victim,
    output logic                    rsp_fill_mru,
    output logic                    follow_bimodal
);
    localparam int SETS  = 1 << IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    set_class_e       set_class;
    logic             draw_hit;
    logic             fill_mru;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim_way;
    logic             bump_up;
    logic             bump_down;

    ains_set_classify #(.IDX_W(IDX_W)) u_classify (
        .set_idx   (lk_set),
        .set_class (set_class)
    );

    ains_draw_lfsr #(.W(DRAW_W), .TAP(DRAW_TAP)) u_draw (
        .clk      (clk),
        .rst_n    (rst_n),
        .draw_hit (draw_hit)
    );

    ains_sel_fsm #(.CTR_W(CTR_W)) u_sel (
        .clk            (clk),
        .rst_n          (rst_n),
        .bump_up        (bump_up),
        .bump_down      (bump_down),
        .follow_bimodal (follow_bimodal)
    );

    always_comb begin
        unique case (set_class)
            SET_LEAD_MRU:     fill_mru = 1'b1;
            SET_LEAD_BIMODAL: fill_mru = draw_hit;
            SET_FOLLOWER:     fill_mru = follow_bimodal ? draw_hit : 1'b1;
            default:          fill_mru = 1'b1;
        endcase
    end

    assign bump_up   = lk_valid && !hit && (set_class == SET_LEAD_MRU);
    assign bump_down = lk_valid && !hit && (set_class == SET_LEAD_BIMODAL);

    ains_recency_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_set     (lk_set),
        .lk_tag     (lk_tag),
        .fill_mru   (fill_mru),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_way      <= '0;
            rsp_victim   <= '0;
            rsp_fill_mru <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                rsp_hit      <= hit;
                rsp_way      <= hit ? hit_way : victim_way;
                rsp_victim   <= victim_way;
                rsp_fill_mru <= !hit && fill_mru;
            end
        end
    end

    AST_RSP_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R2
    AST_MISS_FILLS_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_way == rsp_victim)); // R3
    AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !rsp_fill_mru); // R4
    AST_LEAD_MRU_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !hit && set_class == SET_LEAD_MRU) |=> rsp_fill_mru); // R5
endmodule

// File: tb/adapt_ins_ctrl_bench.sv
`timescale 1ns/1ps
module adapt_ins_ctrl_bench;
    localparam int IDX_W = 6;
    localparam int WAYS  = 4;
    localparam int TAG_W = 12;
    localparam int SETS  = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [IDX_W-1:0] lk_set = '0;
    logic [TAG_W-1:0] lk_tag = '0;
    logic             rsp_valid, rsp_hit, rsp_fill_mru, follow_bimodal;
    logic [1:0]       rsp_way, rsp_victim;

    adapt_ins_ctrl u_adapt_ins_ctrl (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_set(lk_set), .lk_tag(lk_tag),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_victim(rsp_victim),
        .rsp_fill_mru(rsp_fill_mru), .follow_bimodal(follow_bimodal)
    );

    always #2.5 clk = ~clk;

    // behavioural model
    int  ord [SETS][$];
    int  mtag [SETS][WAYS];
    bit  mvld [SETS][WAYS];
    int  sel_ctr;
    int  draw;
    bit  e_valid, e_hit, e_mru, e_follow;
    int  e_way, e_vic;
    string e_fill_req;
    int  checks = 0;
    int  fails = 0;
    int  next_tag = 100;
    bit  done = 1'b0;

    function automatic int set_kind(int s);
        int lo = s % 8;
        int hi = s / 8;
        if (lo == hi) return 1;
        if (lo == 7 - hi) return 2;
        return 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R2 rsp_valid", rsp_valid, e_valid);
        chk("R8 follow_bimodal", follow_bimodal, e_follow);
        if (e_valid) begin
            chk("R2/R9 rsp_hit", rsp_hit, e_hit);
            chk("R2/R3 rsp_way", rsp_way, e_way);
            chk("R3/R4 rsp_victim", rsp_victim, e_vic);
            chk(e_fill_req, rsp_fill_mru, e_mru);
        end
    endtask

    task automatic to_front(int s, int w);
        foreach (ord[s][i]) begin
            if (ord[s][i] == w) begin
                ord[s].delete(i);
                break;
            end
        end
        ord[s].push_front(w);
    endtask

    // called at a falling edge: checks the previous lookup, drives the next one
    task automatic step(bit v, int s, int t);
        compare();
        lk_valid = v;
        lk_set   = IDX_W'(s);
        lk_tag   = TAG_W'(t);
        e_valid  = v;
        if (v) begin
            int hw = -1;
            int k  = set_kind(s);
            for (int w = 0; w < WAYS; w++)
                if (mvld[s][w] && mtag[s][w] == t) hw = w;
            e_vic = ord[s][WAYS-1];
            e_fill_req = (k == 1) ? "R5 fill_mru" : (k == 2) ? "R6 fill_mru" : "R7 fill_mru";
            if (hw >= 0) begin
                e_hit = 1'b1; e_way = hw; e_mru = 1'b0;
                to_front(s, hw);
            end else begin
                e_hit = 1'b0; e_way = e_vic;
                mtag[s][e_vic] = t; mvld[s][e_vic] = 1'b1;
                if (k == 1) e_mru = 1'b1;
                else if (k == 2) e_mru = (draw == 31);
                else e_mru = (sel_ctr >= 512) ? (draw == 31) : 1'b1;
                if (e_mru) to_front(s, e_vic);
                if (k == 1 && sel_ctr < 1023) sel_ctr++;
                if (k == 2 && sel_ctr > 0) sel_ctr--;
            end
        end
        e_follow = (sel_ctr >= 512);
        draw = ((draw << 1) & 31) | (((draw >> 4) ^ (draw >> 2)) & 1);
        @(negedge clk);
    endtask

    int lead_mru [8] = '{0, 9, 18, 27, 36, 45, 54, 63};
    int lead_bim [8] = '{7, 14, 21, 28, 35, 42, 49, 56};

    initial begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                ord[s].push_back(w);
                mvld[s][w] = 1'b0;
                mtag[s][w] = 0;
            end
        end
        sel_ctr = 512; draw = 1; e_valid = 1'b0; e_follow = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state visible at the ports
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 follow_bimodal", follow_bimodal, 1);
        rst_n = 1'b1;
        // R1/R3: first miss in a follower set evicts way 3
        step(1, 5, 1);
        step(0, 0, 0);
        chk("R1 first victim", rsp_victim, 3);
        // follower set under bimodal placement, then hits (R4, R7)
        step(1, 5, 2); step(1, 5, 3); step(1, 5, 4);
        step(1, 5, 4); step(1, 5, 1); step(1, 5, 4);
        // R5: drive counter to its upper limit through conventional leaders
        for (int i = 0; i < 700; i++) step(1, lead_mru[i % 8], next_tag++);
        // R6: bimodal leaders, counter down to zero and held there
        for (int i = 0; i < 1100; i++) step(1, lead_bim[i % 8], next_tag++);
        // R7: followers under conventional placement
        for (int i = 0; i < 40; i++) step(1, 1 + (i % 3), 10 + (i % 6));
        // R8: climb back across the midpoint one miss at a time
        for (int i = 0; i < 514; i++) step(1, lead_mru[i % 8], next_tag++);
        for (int i = 0; i < 30; i++) step(1, 3, 20 + (i % 7));
        // R9: back-to-back lookups to the same set
        for (int i = 0; i < 8; i++) begin
            step(1, 12, next_tag);
            step(1, 12, next_tag);
            next_tag++;
        end
        // mixed traffic with a small tag range
        for (int i = 0; i < 2500; i++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, SETS - 1), $urandom_range(0, 5));
        step(0, 0, 0);
        step(0, 0, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule